// File: doc/BRIEF.md
# Flash Read Page Buffer with Sequential Prefetch

This block sits between a bus read port and a slow flash array and keeps four 128-bit lines of array data close to the bus. Each line holds one 16-byte page and is loaded by exactly one array access. A read whose page is already held is answered in the same cycle, without wait states. A read that misses starts one array access, and the requester waits until the array answers. Demand data and prefetched data share the same four lines.

After an eligible read is served, the block looks ahead to the next sequential page. On the first cycle with no request and no array access in flight, it fetches that page into the least recently used line, unless some line already holds it. Eligibility depends on two settings: a per-master enable mask, and separate enables for instruction reads and data reads. Each line tracks a lifecycle state. The states are Invalid, Used, Valid, Prefetched, Busy-bus and Busy-fill. A demand miss evicts by that state order, and age breaks ties. A global invalidate input empties the lines.

The controller runs a three-state machine. The states are `S_IDLE`, `S_DEMAND_FILL` and `S_PREFETCH_FILL`. The transitions are:
- *start-demand*: `S_IDLE` to `S_DEMAND_FILL`, on a miss with a free victim.
- *start-prefetch*: `S_IDLE` to `S_PREFETCH_FILL`, on a pending look-ahead in an idle cycle.
- *fill-complete*: either fill state back to `S_IDLE`, on the array response.

Top module: `flash_pbuf`

## Requirements
- R1: After reset every line is Invalid, no array request is raised, `rd_done` is low, and the first read of any page misses.
- R2: A read whose page is held in a line that is not Busy-fill completes in the same cycle it is presented. Its data is 32-bit word `rd_addr[1:0]` of that line, where word k occupies line bits [32k+31:32k]. No array request is made.
- R3: A miss raises `fl_req` with `fl_page = rd_addr[23:2]`. With an array latency of L cycles after the request edge, the read completes L+1 cycles after it was presented, with the array's word.
- R4: A response with `fl_err=1` and `fl_ecc1=0` is a failed access. A failed demand read completes with `rd_err=1`, and a failed access never validates a line, so the next read of that page misses again.
- R5: A response with `fl_err=1` and `fl_ecc1=1` is a corrected single-bit event. It returns data with `rd_err=0`, and the line is validated.
- R6: A served read schedules a prefetch of page+1 only if `pf_master_en[rd_mid]` is 1 and the enable for its type is 1. The type enable is `pf_instr_en` when `rd_instr=1` and `pf_data_en` otherwise.
- R7: A scheduled prefetch is issued on the first cycle with `rd_req` low and no access in flight. It is dropped when any line already holds that page, and a demand request is always served first.
- R8: A prefetch fills the least recently used line that is not busy. Ages are refreshed on every hit and every good fill.
- R9: A demand miss evicts the first line found in the order Invalid, Used, Valid, Prefetched, with the least recently used line winning a tie. A burst hit leaves its line Used, and busy lines are never evicted.
- R10: A read of a page whose fill is in progress waits for that fill and is then served with no second array access. At most one line is Busy-fill.
- R11: `inv` makes every line Invalid in the next cycle and clears any scheduled prefetch. A fill in flight at that time completes but is not validated.
- R12: At most one array access is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv | input | 1 | Invalidate all lines |
| pf_master_en | input | 4 | Per-master prefetch enable, indexed by `rd_mid` |
| pf_instr_en | input | 1 | Allow instruction reads to trigger prefetch |
| pf_data_en | input | 1 | Allow data reads to trigger prefetch |
| rd_req | input | 1 | Read request, held until `rd_done` |
| rd_addr | input | 24 | Word address; bits [23:2] select the page |
| rd_mid | input | 2 | Requesting master number |
| rd_instr | input | 1 | 1 = instruction fetch, 0 = data read |
| rd_burst | input | 1 | 1 = beat of a burst, 0 = single read |
| rd_done | output | 1 | Read completes this cycle |
| rd_data | output | 32 | Read data, valid with `rd_done` |
| rd_err | output | 1 | Read terminated with an error, valid with `rd_done` |
| fl_req | output | 1 | Start one array access (one-cycle pulse) |
| fl_page | output | 22 | Page number for the array access |
| fl_rsp | input | 1 | Array response strobe |
| fl_rdata | input | 128 | Array line data |
| fl_err | input | 1 | Access terminated abnormally |
| fl_ecc1 | input | 1 | With `fl_err`, marks a corrected single-bit event |

## Verification
The prefetch gate is swept exhaustively over every master number, both access types and all four type-enable settings under a mixed master mask. Each case tells an issued look-ahead apart from a suppressed one by counting array requests and by whether the next page then hits. Replacement is driven with two patterns: one where only age differs, and one where a burst-used line competes with an older single-read line, so the state order must beat age. Error, corrected and good responses are compared line by line on re-read. Other runs place a read on a line that is still filling, or an invalidate while a fill is in flight, to separate waiting from re-fetching and discarding from validating.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
    // Line lifecycle; numeric order is the eviction order for the first four.
    typedef enum logic [2:0] {
        B_INVALID   = 3'd0,
        B_USED      = 3'd1,
        B_VALID     = 3'd2,
        B_PREF      = 3'd3,
        B_BUSY_BUS  = 3'd4,
        B_BUSY_FILL = 3'd5
    } buf_st_t;

    typedef enum logic [1:0] {
        S_IDLE          = 2'd0,
        S_DEMAND_FILL   = 2'd1,
        S_PREFETCH_FILL = 2'd2
    } ctl_st_t;
endpackage

// File: rtl/pbuf_match.sv
module pbuf_match
    import pbuf_pkg::*;
#(
    parameter int NBUF   = 4,
    parameter int PAGE_W = 22
) (
    input  logic [NBUF-1:0][2:0]        st,
    input  logic [NBUF-1:0][PAGE_W-1:0] tag,
    input  logic [PAGE_W-1:0]           page,
    output logic [NBUF-1:0]             hit_vec,
    output logic [NBUF-1:0]             fill_vec
);
    for (genvar i = 0; i < NBUF; i++) begin : g_cmp
        logic same;
        assign same        = (tag[i] == page);
        assign hit_vec[i]  = same && (st[i] != B_INVALID) && (st[i] != B_BUSY_FILL);
        assign fill_vec[i] = same && (st[i] == B_BUSY_FILL);
    end
endmodule

// File: rtl/pbuf_pick.sv
module pbuf_pick
    import pbuf_pkg::*;
#(
    parameter int NBUF     = 4,
    parameter int AGE_W    = 2,
    parameter bit USE_PRIO = 1'b1
) (
    input  logic [NBUF-1:0][2:0]       st,
    input  logic [NBUF-1:0][AGE_W-1:0] age,
    output logic [AGE_W-1:0]           idx,
    output logic                       found
);
    localparam int KEY_W = AGE_W + 2;

    logic [NBUF-1:0][KEY_W-1:0] key;
    logic [NBUF-1:0]            elig;

    for (genvar i = 0; i < NBUF; i++) begin : g_key
        assign elig[i] = (st[i] <= B_PREF);
        if (USE_PRIO) begin : g_prio
            assign key[i] = {2'd3 - st[i][1:0], age[i]};
        end else begin : g_age
            assign key[i] = {2'b00, age[i]};
        end
    end

    always_comb begin
        logic [KEY_W-1:0] best;
        best  = '0;
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < NBUF; i++) begin
            if (elig[i] && (!found || key[i] > best)) begin
                best  = key[i];
                idx   = AGE_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pbuf_lru.sv
module pbuf_lru #(
    parameter int NBUF  = 4,
    parameter int AGE_W = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       t0_en,
    input  logic [AGE_W-1:0]           t0_idx,
    input  logic                       t1_en,
    input  logic [AGE_W-1:0]           t1_idx,
    output logic [NBUF-1:0][AGE_W-1:0] age
);
    logic [NBUF-1:0][AGE_W-1:0] age_q, age_d;

    function automatic logic [NBUF-1:0][AGE_W-1:0] touch(
        input logic [NBUF-1:0][AGE_W-1:0] a,
        input logic [AGE_W-1:0]           k
    );
        logic [AGE_W-1:0] was;
        was = a[k];
        for (int i = 0; i < NBUF; i++) begin
            if (AGE_W'(i) == k)  a[i] = '0;
            else if (a[i] < was) a[i] = a[i] + AGE_W'(1);
        end
        return a;
    endfunction

    always_comb begin
        age_d = age_q;
        if (t0_en) age_d = touch(age_d, t0_idx);
        if (t1_en) age_d = touch(age_d, t1_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBUF; i++) age_q[i] <= AGE_W'(i);
        end else begin
            age_q <= age_d;
        end
    end

    assign age = age_q;
endmodule

// File: rtl/flash_pbuf.sv
module flash_pbuf
    import pbuf_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LINE_W = 128,
    parameter int DATA_W = 32,
    parameter int NBUF   = 4,
    parameter int MID_W  = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           inv,
    input  logic [(1<<MID_W)-1:0]          pf_master_en,
    input  logic                           pf_instr_en,
    input  logic                           pf_data_en,
    input  logic                           rd_req,
    input  logic [ADDR_W-1:0]              rd_addr,
    input  logic [MID_W-1:0]               rd_mid,
    input  logic                           rd_instr,
    input  logic                           rd_burst,
    output logic                           rd_done,
    output logic [DATA_W-1:0]              rd_data,
    output logic                           rd_err,
    output logic                           fl_req,
    output logic [ADDR_W-$clog2(LINE_W/DATA_W)-1:0] fl_page,
    input  logic                           fl_rsp,
    input  logic [LINE_W-1:0]              fl_rdata,
    input  logic                           fl_err,
    input  logic                           fl_ecc1
);
    localparam int WSEL_W = $clog2(LINE_W / DATA_W);
    localparam int PAGE_W = ADDR_W - WSEL_W;
    localparam int IDX_W  = $clog2(NBUF);

    // Line storage and control state
    logic [NBUF-1:0][2:0]        buf_st_q;
    logic [NBUF-1:0][PAGE_W-1:0] tag_q;
    logic [NBUF-1:0][LINE_W-1:0] data_q;
    ctl_st_t                     ctl_q, ctl_d;
    logic [IDX_W-1:0]            fill_idx_q;
    logic                        discard_q;
    logic                        pf_pend_q;
    logic [PAGE_W-1:0]           pf_page_q;

    logic [PAGE_W-1:0] req_page;
    logic [WSEL_W-1:0] wsel;
    assign req_page = rd_addr[ADDR_W-1:WSEL_W];
    assign wsel     = rd_addr[WSEL_W-1:0];

    logic [NBUF-1:0] hit_vec, fill_vec, pf_hit_vec, pf_fill_vec;

    pbuf_match #(.NBUF(NBUF), .PAGE_W(PAGE_W)) u_req_match (
        .st(buf_st_q), .tag(tag_q), .page(req_page),
        .hit_vec(hit_vec), .fill_vec(fill_vec)
    );

    pbuf_match #(.NBUF(NBUF), .PAGE_W(PAGE_W)) u_pf_match (
        .st(buf_st_q), .tag(tag_q), .page(pf_page_q),
        .hit_vec(pf_hit_vec), .fill_vec(pf_fill_vec)
    );

    logic [NBUF-1:0][IDX_W-1:0] age;
    logic [IDX_W-1:0]           dem_idx, pf_idx;
    logic                       dem_found, pf_found;

    pbuf_pick #(.NBUF(NBUF), .AGE_W(IDX_W), .USE_PRIO(1'b1)) u_dem_pick (
        .st(buf_st_q), .age(age), .idx(dem_idx), .found(dem_found)
    );

    pbuf_pick #(.NBUF(NBUF), .AGE_W(IDX_W), .USE_PRIO(1'b0)) u_pf_pick (
        .st(buf_st_q), .age(age), .idx(pf_idx), .found(pf_found)
    );

    // Decode of the current cycle
    logic             hit_any, hit_serve, pf_held;
    logic [IDX_W-1:0] hit_idx;
    logic             fill_done, fill_good, dem_fill_done;
    logic             start_dem, start_pf, pf_elig;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end

    assign hit_any       = |hit_vec;
    assign hit_serve     = rd_req && hit_any;
    assign pf_held       = |(pf_hit_vec | pf_fill_vec);
    assign fill_done     = (ctl_q != S_IDLE) && fl_rsp;
    assign fill_good     = fill_done && (!fl_err || fl_ecc1);
    assign dem_fill_done = fill_done && (ctl_q == S_DEMAND_FILL);
    assign pf_elig       = pf_master_en[rd_mid] && (rd_instr ? pf_instr_en : pf_data_en);
    assign start_dem     = (ctl_q == S_IDLE) && rd_req && !hit_any && !(|fill_vec)
                           && dem_found && !inv;
    assign start_pf      = (ctl_q == S_IDLE) && !rd_req && pf_pend_q && !pf_held
                           && pf_found && !inv;

    // State register
    always_ff @(posedge clk) begin
        if (rst) ctl_q <= S_IDLE;
        else     ctl_q <= ctl_d;
    end

    // Next-state decode
    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q)
            S_IDLE: begin
                if (start_dem)     ctl_d = S_DEMAND_FILL;
                else if (start_pf) ctl_d = S_PREFETCH_FILL;
            end
            S_DEMAND_FILL:   if (fl_rsp) ctl_d = S_IDLE;
            S_PREFETCH_FILL: if (fl_rsp) ctl_d = S_IDLE;
            default:         ctl_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        fl_req  = start_dem || start_pf;
        fl_page = start_dem ? req_page : pf_page_q;
        rd_done = hit_serve || dem_fill_done;
        rd_err  = dem_fill_done && fl_err && !fl_ecc1;
        if (dem_fill_done) rd_data = fl_rdata[wsel*DATA_W +: DATA_W];
        else               rd_data = data_q[hit_idx][wsel*DATA_W +: DATA_W];
    end

    // Line lifecycle, fill bookkeeping and look-ahead scheduling
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBUF; i++) begin
                buf_st_q[i] <= B_INVALID;
                tag_q[i]    <= '0;
            end
            fill_idx_q <= '0;
            discard_q  <= 1'b0;
            pf_pend_q  <= 1'b0;
            pf_page_q  <= '0;
        end else begin
            for (int i = 0; i < NBUF; i++) begin
                if (buf_st_q[i] == B_BUSY_BUS &&
                    !(hit_serve && rd_burst && hit_idx == IDX_W'(i)))
                    buf_st_q[i] <= B_USED;
            end
            if (hit_serve)
                buf_st_q[hit_idx] <= rd_burst ? B_BUSY_BUS : B_VALID;
            if (start_dem) begin
                buf_st_q[dem_idx] <= B_BUSY_FILL;
                tag_q[dem_idx]    <= req_page;
                fill_idx_q        <= dem_idx;
                discard_q         <= 1'b0;
            end
            if (start_pf) begin
                buf_st_q[pf_idx] <= B_BUSY_FILL;
                tag_q[pf_idx]    <= pf_page_q;
                fill_idx_q       <= pf_idx;
                discard_q        <= 1'b0;
                pf_pend_q        <= 1'b0;
            end
            if ((ctl_q == S_IDLE) && !rd_req && pf_pend_q && pf_held)
                pf_pend_q <= 1'b0;
            if (fill_done) begin
                if (fill_good && !discard_q)
                    buf_st_q[fill_idx_q] <= (ctl_q == S_DEMAND_FILL)
                                            ? (rd_burst ? B_USED : B_VALID) : B_PREF;
                else
                    buf_st_q[fill_idx_q] <= B_INVALID;
            end
            if (rd_done && pf_elig) begin
                pf_pend_q <= 1'b1;
                pf_page_q <= req_page + PAGE_W'(1);
            end
            if (inv) begin
                for (int i = 0; i < NBUF; i++) begin
                    if (buf_st_q[i] != B_BUSY_FILL || (fill_done && fill_idx_q == IDX_W'(i)))
                        buf_st_q[i] <= B_INVALID;
                end
                if (ctl_q != S_IDLE && !fill_done) discard_q <= 1'b1;
                pf_pend_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_good) data_q[fill_idx_q] <= fl_rdata;
    end

    pbuf_lru #(.NBUF(NBUF), .AGE_W(IDX_W)) u_lru (
        .clk(clk), .rst(rst),
        .t0_en(fill_good && !discard_q && !inv), .t0_idx(fill_idx_q),
        .t1_en(hit_serve), .t1_idx(hit_idx),
        .age(age)
    );
endmodule

// File: rtl/pbuf_chk.sv
module pbuf_chk
    import pbuf_pkg::*;
#(
    parameter int NBUF = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 inv,
    input logic                 rd_req,
    input logic                 rd_done,
    input logic                 rd_err,
    input logic                 fl_req,
    input logic                 fl_rsp,
    input logic [NBUF-1:0][2:0] st
);
    logic            out_q;
    logic [NBUF-1:0] filling, holding;

    always_ff @(posedge clk) begin
        if (rst)         out_q <= 1'b0;
        else if (fl_req) out_q <= 1'b1;
        else if (fl_rsp) out_q <= 1'b0;
    end

    for (genvar i = 0; i < NBUF; i++) begin : g_v
        assign filling[i] = (st[i] == B_BUSY_FILL);
        assign holding[i] = (st[i] != B_INVALID) && (st[i] != B_BUSY_FILL);
    end

    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !fl_req);

    p_done_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> rd_req);

    p_err_with_done_r4: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> rd_done);

    p_single_fill_r10: assert property (@(posedge clk) disable iff (rst)
        $countones(filling) <= 1);

    p_inv_empties_r11: assert property (@(posedge clk) disable iff (rst)
        inv |=> (holding == '0));

    p_one_outstanding_r12: assert property (@(posedge clk) disable iff (rst)
        out_q |-> !fl_req);
endmodule

bind flash_pbuf pbuf_chk #(.NBUF(NBUF)) u_chk (
    .clk(clk), .rst(rst), .inv(inv), .rd_req(rd_req), .rd_done(rd_done),
    .rd_err(rd_err), .fl_req(fl_req), .fl_rsp(fl_rsp), .st(buf_st_q)
);

// File: tb/flash_pbuf_bench.sv
`timescale 1ns/1ps
module flash_pbuf_bench;
    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         inv = 1'b0;
    logic [3:0]   pf_master_en = '0;
    logic         pf_instr_en = 1'b0, pf_data_en = 1'b0;
    logic         rd_req = 1'b0;
    logic [23:0]  rd_addr = '0;
    logic [1:0]   rd_mid = '0;
    logic         rd_instr = 1'b0, rd_burst = 1'b0;
    logic         rd_done, rd_err, fl_req;
    logic [31:0]  rd_data;
    logic [21:0]  fl_page;
    logic         fl_rsp = 1'b0, fl_err = 1'b0, fl_ecc1 = 1'b0;
    logic [127:0] fl_rdata = '0;

    int n_tot = 0, n_fail = 0, nreq = 0;
    int err_pg = -1, ecc_pg = -1;
    int cnt = 0;
    logic [21:0] m_pg = '0;

    always #10 clk = ~clk;

    flash_pbuf u_flash_pbuf (
        .clk(clk), .rst(rst), .inv(inv), .pf_master_en(pf_master_en),
        .pf_instr_en(pf_instr_en), .pf_data_en(pf_data_en), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_mid(rd_mid), .rd_instr(rd_instr), .rd_burst(rd_burst),
        .rd_done(rd_done), .rd_data(rd_data), .rd_err(rd_err), .fl_req(fl_req),
        .fl_page(fl_page), .fl_rsp(fl_rsp), .fl_rdata(fl_rdata), .fl_err(fl_err),
        .fl_ecc1(fl_ecc1)
    );

    function automatic logic [31:0] wexp(int pg, int w);
        return 32'h5A00_0000 ^ 32'(pg * 4 + w);
    endfunction

    // Array model: answers LAT edges after the request edge
    always @(posedge clk) begin
        fl_rsp <= 1'b0;
        if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                fl_rsp  <= 1'b1;
                fl_err  <= (int'(m_pg) == err_pg) || (int'(m_pg) == ecc_pg);
                fl_ecc1 <= (int'(m_pg) == ecc_pg);
                for (int w = 0; w < 4; w++) fl_rdata[w*32 +: 32] <= wexp(int'(m_pg), w);
            end
        end
        if (fl_req) begin
            m_pg <= fl_page;
            cnt  <= LAT;
            nreq <= nreq + 1;
        end
    end

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_tot++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input int pg, input int w, input int mid, input bit ins, input bit bur,
                      output logic [31:0] d, output bit e, output int waits);
        bit got;
        got = 1'b0;
        waits = 0;
        @(negedge clk);
        rd_req = 1'b1; rd_addr = 24'(pg * 4 + w); rd_mid = 2'(mid);
        rd_instr = ins; rd_burst = bur;
        while (!got) begin
            #2;
            if (rd_done) begin
                d = rd_data; e = rd_err; got = 1'b1;
                @(posedge clk); #1;
                rd_req = 1'b0; rd_burst = 1'b0;
            end else begin
                @(negedge clk);
                waits++;
            end
        end
    endtask

    task automatic pulse_inv();
        @(negedge clk); inv = 1'b1;
        @(negedge clk); inv = 1'b0;
    endtask

    // Plain read with data check; reports whether it hit
    task automatic rdc(input int pg, input int w, input int mid, input bit ins, input bit bur,
                       input string rq, output bit hit);
        logic [31:0] d; bit e; int wt;
        rd(pg, w, mid, ins, bur, d, e, wt);
        chk(d == wexp(pg, w) && !e, rq, d, wexp(pg, w));
        hit = (wt == 0);
    endtask

    initial begin
        #(200000 * 20);
        n_tot++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end

    initial begin
        logic [31:0] d; bit e; int wt; int n0; bit h;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        chk(!rd_done && !fl_req, "R1 reset outputs", {rd_done, fl_req}, 0);

        // R1/R3: first read misses with exact latency
        rd(5, 2, 0, 1'b0, 1'b0, d, e, wt);
        chk(wt == LAT + 1, "R3 miss latency", wt, LAT + 1);
        chk(d == wexp(5, 2), "R3 miss data", d, wexp(5, 2));
        // R2: every word of the held page hits with no array access
        n0 = nreq;
        for (int w = 0; w < 4; w++) begin
            rd(5, w, 0, 1'b0, 1'b0, d, e, wt);
            chk(wt == 0 && d == wexp(5, w), "R2 zero-wait hit", {wt, d}, {0, wexp(5, w)});
        end
        idle(4);
        chk(nreq == n0, "R2 no array access on hit", nreq - n0, 0);

        // R6/R7: exhaustive gate sweep, mask 0101
        pf_master_en = 4'b0101;
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int mid = 0; mid < 4; mid++) begin
                for (int ins = 0; ins < 2; ins++) begin
                    int pg; bit el;
                    pg = 200 + 4 * (cfg * 8 + mid * 2 + ins);
                    pf_instr_en = cfg[0]; pf_data_en = cfg[1];
                    el = pf_master_en[mid] && (ins != 0 ? cfg[0] : cfg[1]);
                    idle(8); pulse_inv();
                    n0 = nreq;
                    rdc(pg, 0, mid, 1'(ins), 1'b0, "R6 base read", h);
                    idle(8);
                    chk(nreq - n0 == (el ? 2 : 1), "R6 prefetch gate", nreq - n0, el ? 2 : 1);
                    rdc(pg + 1, 1, 1, 1'b0, 1'b0, "R7 next page data", h);
                    chk(h == el, "R7 next page hit", h, el);
                end
            end
        end

        // R7: prefetch dropped when target already held
        pf_master_en = 4'b0001; pf_instr_en = 1'b1; pf_data_en = 1'b1;
        idle(8); pulse_inv();
        rdc(71, 0, 1, 1'b0, 1'b0, "R7 held setup", h);
        idle(8); n0 = nreq;
        rdc(70, 0, 0, 1'b0, 1'b0, "R7 held trigger", h);
        idle(8);
        chk(nreq - n0 == 1, "R7 prefetch skipped when held", nreq - n0, 1);

        // R7: demand with no idle gap goes first
        idle(8); pulse_inv(); n0 = nreq;
        rdc(60, 0, 0, 1'b0, 1'b0, "R7 demand first a", h);
        rdc(61, 3, 0, 1'b0, 1'b0, "R7 demand first b", h);
        chk(!h, "R7 demand served as miss", h, 0);
        idle(8);
        chk(nreq - n0 == 3, "R7 demand priority count", nreq - n0, 3);

        // R10: read of a page that is still filling
        idle(8); pulse_inv(); n0 = nreq;
        rdc(50, 0, 0, 1'b0, 1'b0, "R10 setup", h);
        idle(1);
        rd(51, 2, 1, 1'b0, 1'b0, d, e, wt);
        chk(wt > 0 && d == wexp(51, 2), "R10 waits for fill", wt, 1);
        idle(8);
        chk(nreq - n0 == 2, "R10 no second access", nreq - n0, 2);

        // R11: invalidate with a prefetch in flight
        idle(8); pulse_inv();
        rdc(96, 0, 0, 1'b0, 1'b0, "R11 setup", h);
        idle(1); pulse_inv(); idle(8);
        rdc(97, 0, 1, 1'b0, 1'b0, "R11 discarded fill", h);
        chk(!h, "R11 in-flight fill not validated", h, 0);

        // R4: failed prefetch never validates
        err_pg = 91;
        idle(8); pulse_inv();
        rdc(90, 0, 0, 1'b0, 1'b0, "R4 setup", h);
        idle(8);
        rd(91, 0, 1, 1'b0, 1'b0, d, e, wt);
        chk(wt > 0 && e, "R4 failed prefetch then demand error", {wt != 0, e}, 3);

        // Remaining tests without prefetch
        pf_master_en = 4'b0000;
        err_pg = 80; ecc_pg = 81;
        idle(8); pulse_inv(); n0 = nreq;
        rd(80, 1, 0, 1'b0, 1'b0, d, e, wt);
        chk(e, "R4 error reported", e, 1);
        rd(80, 1, 0, 1'b0, 1'b0, d, e, wt);
        chk(wt > 0 && e && nreq - n0 == 2, "R4 not validated", nreq - n0, 2);
        rd(81, 3, 0, 1'b0, 1'b0, d, e, wt);
        chk(!e && d == wexp(81, 3), "R5 corrected data", d, wexp(81, 3));
        rd(81, 0, 0, 1'b0, 1'b0, d, e, wt);
        chk(wt == 0 && !e && d == wexp(81, 0), "R5 corrected validated", wt, 0);

        // R11: plain invalidate
        rdc(95, 0, 0, 1'b0, 1'b0, "R11 fill", h);
        pulse_inv();
        rdc(95, 0, 0, 1'b0, 1'b0, "R11 reread", h);
        chk(!h, "R11 invalidate empties", h, 0);

        // R8/R9: age-only replacement
        idle(4); pulse_inv();
        for (int p = 30; p < 34; p++) rdc(p, 0, 0, 1'b0, 1'b0, "R9 fill", h);
        rdc(30, 0, 0, 1'b0, 1'b0, "R8 touch", h);
        chk(h, "R8 touched line hits", h, 1);
        rdc(34, 0, 0, 1'b0, 1'b0, "R9 new page", h);
        for (int p = 32; p < 35; p++) begin
            rdc(p, 1, 0, 1'b0, 1'b0, "R8 survivor", h);
            chk(h, "R8 survivor hits", p, 1);
        end
        rdc(30, 1, 0, 1'b0, 1'b0, "R8 recent", h);
        chk(h, "R8 recently used kept", h, 1);
        rdc(31, 1, 0, 1'b0, 1'b0, "R8 victim", h);
        chk(!h, "R8 oldest line evicted", h, 0);

        // R9: Used outranks an older Valid line
        idle(4); pulse_inv();
        for (int p = 40; p < 44; p++) rdc(p, 0, 0, 1'b0, 1'b0, "R9 fill", h);
        rdc(41, 2, 0, 1'b0, 1'b1, "R9 burst hit", h);
        idle(2);
        rdc(44, 0, 0, 1'b0, 1'b0, "R9 new page", h);
        rdc(40, 0, 0, 1'b0, 1'b0, "R9 older valid", h);
        chk(h, "R9 older Valid line kept", h, 1);
        rdc(41, 0, 0, 1'b0, 1'b0, "R9 used line", h);
        chk(!h, "R9 Used line evicted first", h, 0);

        idle(4);
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end
endmodule